// File: doc/BRIEF.md
# Receive Descriptor Ring Pointer Manager

This block keeps the bookkeeping for a circular ring of receive descriptors that sits in host memory. Software sets up the ring size, the starting head and tail, and an interrupt delay through a small 32-bit register port. Hardware then consumes descriptors one at a time: each completed packet moves the head forward by one slot, and the head wraps back to slot zero at the end of the ring. Software hands new descriptors to hardware by moving the tail forward.

Each descriptor is 16 bytes, and both pointers count in whole descriptors. The block reports whether any descriptor is available to hardware. It refuses to activate receive when the ring is too short, and it flags a head write that arrives while receive is running. It also coalesces receive interrupts. Each consumed descriptor restarts a countdown measured in prescaled ticks, and the interrupt pulse is issued when that countdown expires. A flush command fires a pending interrupt at once.

Top module: `rxr_ptr_mgr`

## Requirements
- R1: The length register at byte offset 0x2808 stores only bits 19:7, so the ring is a whole number of 128-byte blocks. Bits 6:0 and 31:20 ignore writes and read 0.
- R2: When the length field (bits 19:7) is zero, the ring holds fewer than eight descriptors. In that case `cfg_err` is 1 and `rx_active` stays 0 even when `rx_enable` is 1.
- R3: Head is at offset 0x2810 and tail is at 0x2818. Each keeps bits 15:0 of the written word, and bits 31:16 read 0. Any unmapped offset reads 0.
- R4: A `pkt_done` pulse while `desc_avail` is 1 advances the head by one descriptor. The head wraps to 0 when it reaches the ring size in descriptors, which is the byte length divided by 16.
- R5: The ring is empty when head equals tail. `desc_avail` is then 0, and `pkt_done` neither moves the head nor counts as a packet for interrupts.
- R6: A head write while `rx_active` is 0 is accepted. A head write while `rx_active` is 1 leaves the head unchanged and sets `head_err`, which stays set until reset.
- R7: With a delay value of 0, every accepted packet raises `rx_irq` in the cycle after it is accepted.
- R8: With a delay value D greater than 0, each accepted packet reloads the countdown to D ticks. `rx_irq` pulses for exactly one cycle after D ticks with no further packet, and the pending state then clears.
- R9: Writing 1 to bit 31 of the delay register at 0x2820 fires a pending interrupt in the next cycle. This bit always reads 0, the delay value sits in bits 15:0, and a flush with nothing pending produces no pulse.
- R10: One tick occurs every PRESCALE clock cycles. A delay of D therefore makes the interrupt arrive between (D-1)*PRESCALE+1 and D*PRESCALE cycles after the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rx_enable | input | 1 | Receive enable requested by software |
| pkt_done | input | 1 | Hardware finished one descriptor |
| rx_active | output | 1 | Receive is enabled and the configuration is legal |
| desc_avail | output | 1 | At least one descriptor is owned by hardware |
| cfg_err | output | 1 | Ring shorter than eight descriptors |
| head_err | output | 1 | Sticky flag for a head write while active |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that `pkt_done` and `reg_wr` are single-cycle, synchronous strobes. They also assume that software never loads a head or tail at or beyond the ring size, because wrap detection compares for equality only. The stimulus follows these rules: every write and packet is one clock wide, both pointers are always programmed below the eight-descriptor ring in use, and PRESCALE is shortened to 4 so that the delay windows stay short.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int PTR_W  = 16;
    localparam int LEN_W  = 13;
    localparam int DLY_W  = 16;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] OFS_LEN  = 16'h2808;
    localparam logic [ADDR_W-1:0] OFS_HEAD = 16'h2810;
    localparam logic [ADDR_W-1:0] OFS_TAIL = 16'h2818;
    localparam logic [ADDR_W-1:0] OFS_DLY  = 16'h2820;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } ring_st_t;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             pend;
        logic             irq;
    } coal_st_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [DLY_W-1:0] dly;
        logic             herr;
    } cfg_st_t;
endpackage

// File: rtl/rxr_tick.sv
module rxr_tick #(
    parameter int PRESCALE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = (pre_q == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R10
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_i,
    input  logic             active_i,
    input  logic             head_we_i,
    input  logic             tail_we_i,
    input  logic [PTR_W-1:0] ptr_wdata_i,
    input  logic             pkt_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             empty_o,
    output logic             adv_o
);
    localparam int SZ_W = LEN_W + 3;

    ring_st_t st_d, st_q;
    logic [SZ_W-1:0]  ring_sz;
    logic [PTR_W:0]   head_inc;

    assign ring_sz  = {len_i, 3'b000};
    assign head_inc = {1'b0, st_q.head} + 1'b1;
    assign empty_o  = (st_q.head == st_q.tail);
    assign adv_o    = pkt_i && active_i && !empty_o;

    always_comb begin
        st_d = st_q;
        if (head_we_i) begin
            st_d.head = ptr_wdata_i;
        end else if (adv_o) begin
            if (head_inc == (PTR_W+1)'(ring_sz)) st_d.head = '0;
            else                                  st_d.head = head_inc[PTR_W-1:0];
        end
        if (tail_we_i) st_d.tail = ptr_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o = st_q.head;
    assign tail_o = st_q.tail;

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !head_we_i) |=> $stable(head_o)); // R5
endmodule

// File: rtl/rxr_coalesce.sv
module rxr_coalesce
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_i,
    input  logic             tick_i,
    input  logic             flush_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             irq_o
);
    coal_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (pkt_i) begin
            if (dly_i == '0) begin
                st_d.irq  = 1'b1;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
                st_d.cnt  = dly_i;
            end
        end else if (st_q.pend) begin
            if (flush_i) begin
                st_d.irq  = 1'b1;
                st_d.pend = 1'b0;
            end else if (tick_i) begin
                if (st_q.cnt <= 1) begin
                    st_d.irq  = 1'b1;
                    st_d.pend = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_i && dly_i == '0) |=> irq_o); // R7
    AST_FLUSH_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && flush_i && !pkt_i) |=> irq_o); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(st_q.pend || pkt_i)); // R8
endmodule

// File: rtl/rxr_ptr_mgr.sv
module rxr_ptr_mgr
    import rxr_pkg::*;
#(
    parameter int PRESCALE = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [15:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_enable,
    input  logic        pkt_done,
    output logic        rx_active,
    output logic        desc_avail,
    output logic        cfg_err,
    output logic        head_err,
    output logic        rx_irq
);
    cfg_st_t cfg_d, cfg_q;
    logic [PTR_W-1:0] head, tail;
    logic empty, adv, tick, flush;
    logic wr_len, wr_head, wr_tail, wr_dly, head_we;
    logic unused_bits;

    assign wr_len  = reg_wr && (reg_addr == OFS_LEN);
    assign wr_head = reg_wr && (reg_addr == OFS_HEAD);
    assign wr_tail = reg_wr && (reg_addr == OFS_TAIL);
    assign wr_dly  = reg_wr && (reg_addr == OFS_DLY);
    assign flush   = wr_dly && reg_wdata[31];
    assign head_we = wr_head && !rx_active;

    assign cfg_err   = (cfg_q.len == '0);
    assign rx_active = rx_enable && !cfg_err;
    assign desc_avail = rx_active && !empty;
    assign head_err  = cfg_q.herr;
    assign unused_bits = ^{reg_wdata[30:20], reg_wdata[6:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_len) cfg_d.len = reg_wdata[19:7];
        if (wr_dly) cfg_d.dly = reg_wdata[DLY_W-1:0];
        if (wr_head && rx_active) cfg_d.herr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (reg_addr)
            OFS_LEN:  reg_rdata = {12'h000, cfg_q.len, 7'h00};
            OFS_HEAD: reg_rdata = {16'h0000, head};
            OFS_TAIL: reg_rdata = {16'h0000, tail};
            OFS_DLY:  reg_rdata = {16'h0000, cfg_q.dly};
            default:  reg_rdata = '0;
        endcase
    end

    rxr_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rxr_ring u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_i       (cfg_q.len),
        .active_i    (rx_active),
        .head_we_i   (head_we),
        .tail_we_i   (wr_tail),
        .ptr_wdata_i (reg_wdata[PTR_W-1:0]),
        .pkt_i       (pkt_done),
        .head_o      (head),
        .tail_o      (tail),
        .empty_o     (empty),
        .adv_o       (adv)
    );

    rxr_coalesce u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt_i   (adv),
        .tick_i  (tick),
        .flush_i (flush),
        .dly_i   (cfg_q.dly),
        .irq_o   (rx_irq)
    );

    AST_HERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        head_err |=> head_err); // R6
    AST_HEAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_active && wr_head && !adv) |=> $stable(head)); // R6
    AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_len && reg_wdata[19:7] == '0) |=> !rx_active); // R2
endmodule

// File: tb/test_rxr_ptr_mgr.sv
module test_rxr_ptr_mgr;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_enable = 1'b0;
    logic        pkt_done = 1'b0;
    logic        rx_active, desc_avail, cfg_err, head_err, rx_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxr_ptr_mgr #(.PRESCALE(P)) i_rxr_ptr_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_enable(rx_enable),
        .pkt_done(pkt_done), .rx_active(rx_active), .desc_avail(desc_avail),
        .cfg_err(cfg_err), .head_err(head_err), .rx_irq(rx_irq)
    );

    // {offset, write data, expected read back}
    localparam logic [79:0] VEC [6] = '{
        {16'h2808, 32'hFFFF_FFFF, 32'h000F_FF80},  // R1
        {16'h2808, 32'h0000_007F, 32'h0000_0000},  // R1
        {16'h2810, 32'hABCD_1234, 32'h0000_1234},  // R3
        {16'h2818, 32'h1234_5678, 32'h0000_5678},  // R3
        {16'h2820, 32'h8000_0005, 32'h0000_0005},  // R9
        {16'h2800, 32'hFFFF_FFFF, 32'h0000_0000}   // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pkt();
        pkt_done = 1'b1;
        cyc();
        pkt_done = 1'b0;
    endtask

    // cycles from the packet edge to the interrupt, and how long it stays high
    task automatic measure(output int lat, output int width);
        lat = -1; width = 0;
        for (int n = 0; n < 20; n++) begin
            if (rx_irq) begin
                if (lat < 0) lat = n;
                width++;
            end
            cyc();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int lat, width, early;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // reset state
        rd(16'h2808, r); check("R1 len reset", r, 0);
        rd(16'h2810, r); check("R3 head reset", r, 0);
        check("R2 cfg_err at reset", {31'b0, cfg_err}, 1);
        check("R7 irq at reset", {31'b0, rx_irq}, 0);
        check("R6 head_err at reset", {31'b0, head_err}, 0);

        // register vectors
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][79:64], VEC[i][63:32]);
            rd(VEC[i][79:64], r);
            check("R1/R3/R9 register vector", r, VEC[i][31:0]);
        end

        // R2: too short a ring blocks receive
        wr(16'h2808, 32'h0);
        rx_enable = 1'b1; #1;
        check("R2 rx_active with empty length", {31'b0, rx_active}, 0);
        check("R2 cfg_err", {31'b0, cfg_err}, 1);
        rx_enable = 1'b0;

        // eight-descriptor ring, head 6, tail 1
        wr(16'h2808, 32'h80);
        wr(16'h2810, 32'd6);
        wr(16'h2818, 32'd1);
        wr(16'h2820, 32'd0);
        rx_enable = 1'b1; #1;
        check("R2 rx_active with legal ring", {31'b0, rx_active}, 1);
        check("R5 desc_avail", {31'b0, desc_avail}, 1);
        pkt();
        rd(16'h2810, r); check("R4 head advance", r, 7);
        check("R7 zero-delay irq", {31'b0, rx_irq}, 1);
        cyc();
        check("R7 irq one cycle", {31'b0, rx_irq}, 0);
        pkt();
        rd(16'h2810, r); check("R4 head wrap", r, 0);
        pkt();
        rd(16'h2810, r); check("R4 head after wrap", r, 1);
        check("R5 empty ring", {31'b0, desc_avail}, 0);
        cyc();
        pkt();
        rd(16'h2810, r); check("R5 pkt on empty ring", r, 1);
        check("R5 no irq on empty ring", {31'b0, rx_irq}, 0);

        // R6: head write while active
        wr(16'h2810, 32'd3);
        rd(16'h2810, r); check("R6 head locked", r, 1);
        check("R6 head_err set", {31'b0, head_err}, 1);
        repeat (3) cyc();
        check("R6 head_err sticky", {31'b0, head_err}, 1);

        // R8/R10: delayed interrupt
        wr(16'h2820, 32'd3);
        wr(16'h2818, 32'd6);
        pkt();
        measure(lat, width);
        check("R10 delay window", {31'b0, (lat >= (2*P+1) && lat <= 3*P)}, 1);
        check("R8 pulse width", width, 1);

        // R8: restart by a second packet
        pkt();
        early = 0;
        for (int n = 0; n < 6; n++) begin
            if (rx_irq) early++;
            cyc();
        end
        pkt();
        measure(lat, width);
        check("R8 no irq before restart", early, 0);
        check("R8 restarted window", {31'b0, (lat >= (2*P+1) && lat <= 3*P)}, 1);
        check("R8 restarted pulse width", width, 1);

        // R9: flush
        pkt();
        cyc(); cyc();
        wr(16'h2820, 32'h8000_0003);
        check("R9 flush fires", {31'b0, rx_irq}, 1);
        rd(16'h2820, r); check("R9 flush reads 0", r, 3);
        early = 0;
        for (int n = 0; n < 20; n++) begin
            if (rx_irq) early++;
            cyc();
        end
        check("R9 single pulse after flush", early, 1);
        wr(16'h2820, 32'h8000_0003);
        check("R9 flush with nothing pending", {31'b0, rx_irq}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule